// File: doc/BRIEF.md
# Debug Address Breakpoint Unit

This block watches the processor's bus and raises a debug trap when an access hits one of four watched addresses. Each watch slot holds a 32-bit linear address. A shared control word gives every slot two enables, an access-type selector and a region length. Software programs the slots through a small register port. The trap then fires whenever an enabled slot sees a matching instruction fetch, memory data access or I/O access.

Each slot has two enables. A per-task ("local") enable is wiped by a task-switch pulse, because the watched address may no longer mean anything in the new task. A "global" enable survives the switch. A slot is armed when either enable is set.

Every hit registers a one-cycle trap pulse. It also sets a sticky per-slot bit in a status register, and software clears that bit by writing zero to it.

Bus accesses are assumed to be aligned to their own size.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After a synchronous active-low reset, `trap` is 0 and `hit_status` is 0. Every register reads as zero.
- R2: Register map on `reg_addr`: 0..3 are the slot addresses, 4 is the control word and 5 is the status. A write lands on the rising edge where `reg_we` is 1, and `reg_rdata` shows the selected register without delay. Any other address reads 0.
- R3: Control word layout for slot i: the local enable is at bit i and the global enable is at bit 4+i. The type is at bits [9+2i:8+2i] and the length is at bits [17+2i:16+2i]. Bits 24..31 read 0. A slot matches only when its local or its global enable is 1; with both at 0 it never matches.
- R4: A cycle with `task_switch`=1 clears all local enables and leaves the global enables unchanged. If a control write happens in the same cycle, the local enables are still cleared.
- R5: Type 00 (execute) matches only a fetch (`bus_kind`=00) of size 00 (one byte) at exactly the slot address. The slot's length field has no effect for this type.
- R6: Bus kinds are 00 fetch, 01 memory read, 10 memory write and 11 I/O. Type 01 matches memory writes only, type 10 matches I/O accesses only, and type 11 matches memory reads and writes.
- R7: Length and access-size codes are 00 = 1 byte, 01 = 2 bytes, 11 = 4 bytes and 10 = 8 bytes. The addresses are compared with the low log2(max(slot length, access size)) bits ignored. The result is a match whenever any byte of the access overlaps the watched region.
- R8: `trap` is 1 in the cycle after an edge at which `bus_valid` was 1 and some armed slot matched, and 0 otherwise. No match is possible while `bus_valid` is 0.
- R9: Status bit i (register 5, bits [3:0], also on `hit_status`) sets when slot i matches. It stays set until a status write with bit i = 0 clears it; writing 1 keeps it. A hit in the same cycle as a clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_kind | input | 2 | Bus cycle kind: fetch, memory read, memory write, I/O |
| bus_addr | input | 32 | Linear address of the bus cycle |
| bus_size | input | 2 | Access size code |
| task_switch | input | 1 | One-cycle task-switch indication |
| trap | output | 1 | Debug trap pulse |
| hit_status | output | 4 | Sticky per-slot hit bits |

## Verification
Some properties are checked on every cycle:
- Local enables are empty after a task switch, and global enables are unchanged by it.
- Status bits never drop without a status write.
- A trap always follows a valid bus cycle and comes with a set status bit.
- An execute slot never fires on anything but a one-byte fetch.

Other behaviour can only be shown by the bench's scenarios, which compare outputs with expected values:
- The overlap arithmetic for each pair of slot length and access size.
- The per-type filtering of the bus kinds.
- Readback of the register map.
- A hit that coincides with a status clear.

// File: rtl/dbg_bkpt_pkg.sv
// Package: shared encodings for the breakpoint unit.
// Assumes: 2-bit bus kind, type and length codes as listed in the brief.
package dbg_bkpt_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_MRD   = 2'b01,
        KIND_MWR   = 2'b10,
        KIND_IO    = 2'b11
    } bus_kind_e;

    typedef enum logic [1:0] {
        BT_EXEC  = 2'b00,
        BT_WRITE = 2'b01,
        BT_IO    = 2'b10,
        BT_RW    = 2'b11
    } bp_type_e;

    // Convert a length/size code into log2 of its byte count.
    function automatic logic [1:0] len_log2(input logic [1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/dbg_bkpt_cmp.sv
// Module: one breakpoint comparator.
// Combinationally decides whether the current bus cycle hits this slot.
// It qualifies the match by access type and compares the addresses at the
// coarser of the slot length and the access size.
// Assumes: bus accesses are aligned to their own size.
module dbg_bkpt_cmp
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bp_addr,
    input  logic [1:0]        bp_type,
    input  logic [1:0]        bp_len,
    input  logic              bp_active,
    input  logic              bus_valid,
    input  logic [1:0]        bus_kind,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    output logic              hit
);

    logic [1:0]        bp_shift;
    logic [1:0]        acc_shift;
    logic [1:0]        cmp_shift;
    logic [ADDR_W-1:0] cmp_mask;
    logic              addr_eq;
    logic              type_ok;

    // Pick the comparison granularity: the wider of the region and the access.
    always_comb begin
        bp_shift  = (bp_type == BT_EXEC) ? 2'd0 : len_log2(bp_len);
        acc_shift = len_log2(bus_size);
        cmp_shift = (bp_shift > acc_shift) ? bp_shift : acc_shift;
        cmp_mask  = {ADDR_W{1'b1}} << cmp_shift;
        addr_eq   = ((bp_addr ^ bus_addr) & cmp_mask) == '0;
    end

    // Qualify the bus cycle kind against the slot's access type.
    always_comb begin
        case (bp_type)
            BT_EXEC:  type_ok = (bus_kind == KIND_FETCH) && (bus_size == 2'b00);
            BT_WRITE: type_ok = (bus_kind == KIND_MWR);
            BT_IO:    type_ok = (bus_kind == KIND_IO);
            default:  type_ok = (bus_kind == KIND_MRD) || (bus_kind == KIND_MWR);
        endcase
    end

    // Final hit: valid cycle, armed slot, right kind, overlapping address.
    assign hit = bus_valid && bp_active && type_ok && addr_eq;

    // R5: an execute slot only fires on a one-byte fetch at its exact address
    a_r5_exec_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bp_type == BT_EXEC) |->
            (bus_kind == KIND_FETCH && bus_size == 2'b00 && bus_addr == bp_addr));

    // R6: a write-only slot never fires on a read, fetch or I/O cycle
    a_r6_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bp_type == BT_WRITE) |-> (bus_kind == KIND_MWR));

endmodule

// File: rtl/dbg_bkpt_regs.sv
// Module: software-visible registers of the breakpoint unit.
// Holds the slot addresses, the control fields and the sticky status.
// Applies the task-switch clear to the local enables and serves
// combinational reads.
// Assumes: 6*NUM_BP <= DATA_W so that the control word fits.
module dbg_bkpt_regs #(
    parameter int NUM_BP = 4,
    parameter int DATA_W = 32,
    parameter int RA_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_we,
    input  logic [RA_W-1:0]                reg_addr,
    input  logic [DATA_W-1:0]              reg_wdata,
    output logic [DATA_W-1:0]              reg_rdata,
    input  logic                           task_switch,
    input  logic [NUM_BP-1:0]              hits,
    output logic [NUM_BP-1:0][DATA_W-1:0]  bp_addr,
    output logic [NUM_BP-1:0][1:0]         bp_type,
    output logic [NUM_BP-1:0][1:0]         bp_len,
    output logic [NUM_BP-1:0]              loc_en,
    output logic [NUM_BP-1:0]              glb_en,
    output logic [NUM_BP-1:0]              status
);

    localparam int IDX_W    = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;
    localparam int CTRL_IDX = NUM_BP;
    localparam int STAT_IDX = NUM_BP + 1;
    localparam int TYPE_LSB = 2 * NUM_BP;
    localparam int LEN_LSB  = 4 * NUM_BP;

    logic              ctrl_wr;
    logic              stat_wr;
    logic [DATA_W-1:0] ctrl_word;

    assign ctrl_wr = reg_we && (reg_addr == RA_W'(CTRL_IDX));
    assign stat_wr = reg_we && (reg_addr == RA_W'(STAT_IDX));

    // Slot address registers: loaded by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_addr <= '0;
        end else if (reg_we && (reg_addr < RA_W'(NUM_BP))) begin
            bp_addr[reg_addr[IDX_W-1:0]] <= reg_wdata;
        end
    end

    // Control fields: written by software; a task switch wipes the local enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_en  <= '0;
            glb_en  <= '0;
            bp_type <= '0;
            bp_len  <= '0;
        end else begin
            if (ctrl_wr) begin
                loc_en <= reg_wdata[NUM_BP-1:0];
                glb_en <= reg_wdata[2*NUM_BP-1:NUM_BP];
                for (int i = 0; i < NUM_BP; i++) begin
                    bp_type[i] <= reg_wdata[TYPE_LSB+2*i +: 2];
                    bp_len[i]  <= reg_wdata[LEN_LSB+2*i +: 2];
                end
            end
            if (task_switch) begin
                loc_en <= '0;
            end
        end
    end

    // Sticky status: software clears with zeros; new hits always set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (stat_wr ? (status & reg_wdata[NUM_BP-1:0]) : status) | hits;
        end
    end

    // Assemble the control word image for readback.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[NUM_BP-1:0]        = loc_en;
        ctrl_word[2*NUM_BP-1:NUM_BP] = glb_en;
        for (int i = 0; i < NUM_BP; i++) begin
            ctrl_word[TYPE_LSB+2*i +: 2] = bp_type[i];
            ctrl_word[LEN_LSB+2*i +: 2]  = bp_len[i];
        end
    end

    // Read multiplexer for the register port.
    always_comb begin
        if (reg_addr < RA_W'(NUM_BP)) begin
            reg_rdata = bp_addr[reg_addr[IDX_W-1:0]];
        end else if (reg_addr == RA_W'(CTRL_IDX)) begin
            reg_rdata = ctrl_word;
        end else if (reg_addr == RA_W'(STAT_IDX)) begin
            reg_rdata = DATA_W'(status);
        end else begin
            reg_rdata = '0;
        end
    end

    // R4: the cycle after a task switch has no local enable left
    a_r4_local_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> (loc_en == '0));

    // R4: global enables survive a task switch
    a_r4_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (task_switch && !ctrl_wr) |=> $stable(glb_en));

    // R9: without a status write no status bit drops
    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/dbg_bkpt_unit.sv
// Module: top of the debug address breakpoint unit.
// Instances the register block and one comparator per slot. The hits are
// combined into a registered one-cycle trap.
// Assumes: aligned bus accesses; task_switch is a single-cycle indication.
module dbg_bkpt_unit #(
    parameter int NUM_BP = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              bus_valid,
    input  logic [1:0]        bus_kind,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              task_switch,
    output logic              trap,
    output logic [NUM_BP-1:0] hit_status
);

    localparam int RA_W = 3;

    logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
    logic [NUM_BP-1:0][1:0]        bp_type;
    logic [NUM_BP-1:0][1:0]        bp_len;
    logic [NUM_BP-1:0]             loc_en;
    logic [NUM_BP-1:0]             glb_en;
    logic [NUM_BP-1:0]             hits;
    logic                          trap_q;

    dbg_bkpt_regs #(
        .NUM_BP (NUM_BP),
        .DATA_W (ADDR_W),
        .RA_W   (RA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .task_switch (task_switch),
        .hits        (hits),
        .bp_addr     (bp_addr),
        .bp_type     (bp_type),
        .bp_len      (bp_len),
        .loc_en      (loc_en),
        .glb_en      (glb_en),
        .status      (hit_status)
    );

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        dbg_bkpt_cmp #(
            .ADDR_W (ADDR_W)
        ) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .bp_addr   (bp_addr[g]),
            .bp_type   (bp_type[g]),
            .bp_len    (bp_len[g]),
            .bp_active (loc_en[g] | glb_en[g]),
            .bus_valid (bus_valid),
            .bus_kind  (bus_kind),
            .bus_addr  (bus_addr),
            .bus_size  (bus_size),
            .hit       (hits[g])
        );
    end

    // Trap register: one cycle high after any armed slot matched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q <= 1'b0;
        end else begin
            trap_q <= |hits;
        end
    end

    assign trap = trap_q;

    // R8: a trap is only ever caused by a valid bus cycle
    a_r8_trap_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(bus_valid));

    // R9: a trap always comes with at least one set status bit
    a_r9_trap_marks_status: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (hit_status != '0));

endmodule

// File: tb/dbg_bkpt_unit_tb.sv
module dbg_bkpt_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [1:0]  bus_kind = '0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        task_switch = 1'b0;
    logic        trap;
    logic [3:0]  hit_status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic       trap;
        logic [3:0] stat;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    dbg_bkpt_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .bus_valid   (bus_valid),
        .bus_kind    (bus_kind),
        .bus_addr    (bus_addr),
        .bus_size    (bus_size),
        .task_switch (task_switch),
        .trap        (trap),
        .hit_status  (hit_status)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    // Driver: one bus cycle; pushes the expected trap/status seen after its edge.
    task automatic bus(input logic v, input logic [1:0] k, input logic [31:0] a,
                       input logic [1:0] s, input logic et, input logic [3:0] es,
                       input string tag);
        exp_t e;
        @(negedge clk);
        bus_valid = v; bus_kind = k; bus_addr = a; bus_size = s;
        @(posedge clk);
        #1;
        e.trap = et; e.stat = es; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Monitor: compares the design outputs with the oldest expected item.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(trap === e.trap, {e.tag, " trap"}, 32'(trap), 32'(e.trap));
            check(hit_status === e.stat, {e.tag, " status"}, 32'(hit_status), 32'(e.stat));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(trap === 1'b0, "R1 trap after reset", 32'(trap), 0);
        check(hit_status === 4'b0, "R1 status after reset", 32'(hit_status), 0);
        for (int i = 0; i < 6; i++) rd_check(3'(i), 32'h0, "R1 register cleared");

        // R2: slot addresses and readback
        wr(3'd0, 32'h0000_1000);
        wr(3'd1, 32'h0000_2004);
        wr(3'd2, 32'h0000_3000);
        wr(3'd3, 32'h0000_0080);
        rd_check(3'd1, 32'h0000_2004, "R2 slot1 readback");
        rd_check(3'd3, 32'h0000_0080, "R2 slot3 readback");
        rd_check(3'd6, 32'h0, "R2 unmapped address reads zero");

        // R3: disabled slot never matches
        bus(1, 2'b00, 32'h1000, 2'b00, 0, 4'b0000, "R3 disabled slot");

        // R5 / R8: execute slot 0 with local enable
        wr(3'd4, 32'h0000_0001);
        rd_check(3'd4, 32'h0000_0001, "R2 control readback");
        bus(1, 2'b00, 32'h1000, 2'b00, 1, 4'b0001, "R5 R8 exec hit");
        bus(0, 2'b00, 32'h1000, 2'b00, 0, 4'b0001, "R8 trap is one cycle");
        bus(1, 2'b00, 32'h1000, 2'b01, 0, 4'b0001, "R5 two-byte fetch ignored");
        bus(1, 2'b01, 32'h1000, 2'b00, 0, 4'b0001, "R5 data read ignored");

        // R9: writing 1 keeps, writing 0 clears
        wr(3'd5, 32'h0000_0001);
        rd_check(3'd5, 32'h1, "R9 write one keeps");
        wr(3'd5, 32'h0);
        rd_check(3'd5, 32'h0, "R9 write zero clears");

        // R6 / R7: slot1 write-only, 2-byte region, global enable
        wr(3'd4, 32'h0004_0421);
        bus(1, 2'b10, 32'h2005, 2'b00, 1, 4'b0010, "R7 byte inside 2-byte region");
        bus(1, 2'b01, 32'h2004, 2'b00, 0, 4'b0010, "R6 read ignored by write slot");
        bus(1, 2'b10, 32'h2006, 2'b00, 0, 4'b0010, "R7 byte outside region");
        bus(1, 2'b10, 32'h2000, 2'b11, 0, 4'b0010, "R7 4-byte access below region");
        bus(1, 2'b10, 32'h2000, 2'b10, 1, 4'b0010, "R7 8-byte access covers region");
        wr(3'd5, 32'h0);

        // R6 / R7: slot2 I/O, 4-byte region
        wr(3'd4, 32'h0034_2425);
        bus(1, 2'b11, 32'h3003, 2'b00, 1, 4'b0100, "R6 R7 io hit in 4-byte region");
        bus(1, 2'b10, 32'h3000, 2'b00, 0, 4'b0100, "R6 memory write ignored by io slot");
        wr(3'd5, 32'h0);

        // R6 / R8: slot3 data read/write
        wr(3'd4, 32'h0034_E4A5);
        bus(1, 2'b01, 32'h0080, 2'b00, 1, 4'b1000, "R6 rw slot read");
        bus(1, 2'b10, 32'h0080, 2'b00, 1, 4'b1000, "R6 rw slot write");
        bus(1, 2'b00, 32'h0080, 2'b00, 0, 4'b1000, "R6 rw slot ignores fetch");
        bus(0, 2'b01, 32'h0080, 2'b00, 0, 4'b1000, "R8 no match without valid");
        wr(3'd5, 32'h0);

        // R4: task switch clears local, keeps global
        @(negedge clk); task_switch = 1'b1;
        @(negedge clk); task_switch = 1'b0;
        rd_check(3'd4, 32'h0034_E4A0, "R4 locals cleared");
        bus(1, 2'b00, 32'h1000, 2'b00, 0, 4'b0000, "R4 local slot0 disarmed");
        bus(1, 2'b01, 32'h0080, 2'b00, 1, 4'b1000, "R4 global slot3 armed");
        @(negedge clk);
        task_switch = 1'b1; reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h0034_E4A5;
        @(negedge clk);
        task_switch = 1'b0; reg_we = 1'b0;
        rd_check(3'd4, 32'h0034_E4A0, "R4 switch beats control write");

        // R9: hit coinciding with a clear
        wr(3'd5, 32'h0);
        bus(1, 2'b10, 32'h2004, 2'b00, 1, 4'b0010, "R9 slot1 hit");
        begin
            exp_t e;
            @(negedge clk);
            reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h0;
            bus_valid = 1'b1; bus_kind = 2'b01; bus_addr = 32'h80; bus_size = 2'b00;
            @(posedge clk);
            #1;
            e.trap = 1'b1; e.stat = 4'b1000; e.tag = "R9 hit wins over clear";
            exp_q.push_back(e);
            @(negedge clk);
            reg_we = 1'b0; bus_valid = 1'b0;
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule